// File: doc/BRIEF.md
# Precharged Internal Bus Network

This block models the internal bus fabric of a two-phase NMOS processor at node level, one bit slice per data bit. It has four buses: a special bus, an internal data bus, an address-low bus and an address-high bus. Each bus is fed by its own set of select lines. Any number of those selects may be active at once. The sources are the X, Y, accumulator and stack registers, the two program-counter halves, the ALU result and the input data latch. Two pass links join the special bus to the data bus and to the address-high bus, and each link can carry data in either direction. Two program-counter latch nodes take their next value from the address buses or from the current counter halves.

The fabric runs from a fast system clock. Each processor phase is supplied as a level enable that stays high for one or more fast cycles. Every node is a register. On each fast clock edge, each node takes a combinational function of the previous node values and the current inputs, so any combinational loop is broken. The rules are these:
- A 0 beats a 1, so a bus takes the AND of all its enabled sources.
- A node with no enabled source keeps its value.
- During phase 2 every bus is pulled to all ones.

These rules together let a register be decremented. The special bus is precharged in phase 2 and then left floating in phase 1, so it supplies $FF to the adder.

Top module: `pbus_fabric`

## Requirements
- R1: While `rst` is high at a clock edge, every node is cleared to 0 on that edge: all four buses and both program-counter latch outputs.
- R2: While `ph2` is high, each bus takes all ones on the next edge, unless a source enabled on that bus pulls a bit low.
- R3: When several sources are enabled on one bus, the bus takes the bitwise AND of their values on the next edge.
- R4: A bus, or a program-counter latch node, that has no source enabled, no active precharge and no incoming link transfer keeps its value on every edge.
- R5: When `sb_db_link` is high, the data-bus value is copied onto the special bus only if a local data-bus source is enabled. The special-bus value is copied onto the data bus only if a local special-bus source is enabled. The value copied is the other bus's value before the edge. With the link low, neither bus affects the other.
- R6: `sb_adh_link` joins the special bus and the address-high bus under the same rules as R5. A ground line counts as a local address-high source.
- R7: The input data latch `dl_in` reaches the data, address-low and address-high buses only while `ph1` is high. With `ph1` low, its select lines have no effect.
- R8: `zero_adh_lo` forces address-high bit 0 to 0. `zero_adh_hi` forces address-high bits 7 to 1 to 0. The ground wins over any other address-high source.
- R9: `pcl_nx` takes the AND of `pcl_in` (when `pcl_to_pcl` is set) and the address-low bus (when `adl_to_pcl` is set). `pch_nx` does the same with `pch_in` (`pch_to_pch`) and the address-high bus (`adh_to_pch`).
- R10: Precharging the special bus in phase 2 and then floating it through phase 1 leaves it at $FF. An 8-bit value plus that bus, modulo 256, is the value minus one.
- R11: Each node adds one fast-clock cycle of latency, so a value crossing a link appears on the far bus one edge after it reaches the near bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| ph1 | input | 1 | Phase 1 level enable |
| ph2 | input | 1 | Phase 2 level enable (precharge) |
| x_in | input | W | X register value |
| y_in | input | W | Y register value |
| a_in | input | W | Accumulator value |
| s_in | input | W | Stack register value |
| pcl_in | input | W | Program counter low half |
| pch_in | input | W | Program counter high half |
| alu_in | input | W | ALU result |
| dl_in | input | W | Input data latch |
| y_to_sb | input | 1 | Y drives special bus |
| x_to_sb | input | 1 | X drives special bus |
| s_to_sb | input | 1 | Stack drives special bus |
| alu_to_sb | input | 1 | ALU drives special bus |
| a_to_sb | input | 1 | Accumulator drives special bus |
| a_to_db | input | 1 | Accumulator drives data bus |
| pch_to_db | input | 1 | PC high drives data bus |
| pcl_to_db | input | 1 | PC low drives data bus |
| dl_to_db | input | 1 | Data latch drives data bus in phase 1 |
| s_to_adl | input | 1 | Stack drives address-low bus |
| alu_to_adl | input | 1 | ALU drives address-low bus |
| pcl_to_adl | input | 1 | PC low drives address-low bus |
| dl_to_adl | input | 1 | Data latch drives address-low bus in phase 1 |
| pch_to_adh | input | 1 | PC high drives address-high bus |
| dl_to_adh | input | 1 | Data latch drives address-high bus in phase 1 |
| zero_adh_lo | input | 1 | Ground address-high bit 0 |
| zero_adh_hi | input | 1 | Ground address-high bits 7..1 |
| sb_db_link | input | 1 | Two-way link special bus / data bus |
| sb_adh_link | input | 1 | Two-way link special bus / address-high bus |
| pcl_to_pcl | input | 1 | PC low latch takes pcl_in |
| adl_to_pcl | input | 1 | PC low latch takes address-low bus |
| pch_to_pch | input | 1 | PC high latch takes pch_in |
| adh_to_pch | input | 1 | PC high latch takes address-high bus |
| sb_q | output | W | Special bus node |
| db_q | output | W | Data bus node |
| adl_q | output | W | Address-low bus node |
| adh_q | output | W | Address-high bus node |
| pcl_nx | output | W | Next program-counter low latch input |
| pch_nx | output | W | Next program-counter high latch input |

## Verification
Two functions can land on the same edge.

The first case is a ground line and a real address-high source enabled together. The bench sets the address-high bus to all ones and then enables the counter-high drive together with a ground line. The only correct result is the ground pattern.

The second case is a precharge followed by a float, set against a real drive. For every 8-bit value, the bench precharges the special bus and floats it for two phase-1 cycles. It then adds the held bus to the value with its own adder and drives the sum back onto the bus. It checks the result against the value minus one, worked out arithmetically. The same sweeps also check links by driving one side and watching the far bus one edge later.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Number of select inputs feeding each node kind (precharge counted).
  localparam int SB_N  = 8;
  localparam int DB_N  = 6;
  localparam int ADL_N = 5;
  localparam int ADH_N = 5;
  localparam int PC_N  = 2;

  // Shared control word, identical for every bit slice.
  typedef struct packed {
    logic ph1;
    logic ph2;
    logic y_sb, x_sb, s_sb, alu_sb, a_sb;
    logic a_db, pch_db, pcl_db, dl_db;
    logic s_adl, alu_adl, pcl_adl, dl_adl;
    logic pch_adh, dl_adh, z_lo, z_hi;
    logic lnk_db, lnk_adh;
    logic pcl_pcl, adl_pcl, pch_pch, adh_pch;
  } pbus_ctl_t;

  // One bit of every source register.
  typedef struct packed {
    logic x, y, a, s, pcl, pch, alu, dl;
  } pbus_src_t;

endpackage

// File: rtl/pbus_node.sv
// One storage node: wired-AND of every selected input, holds when none is selected.
module pbus_node #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] din,
  output logic         q
);
  logic nxt;

  always_comb begin
    if (|sel) nxt = &(din | ~sel);
    else      nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/pbus_slice.sv
// One bit of the bus fabric: four buses, two links, two PC latch nodes.
module pbus_slice
  import pbus_pkg::*;
#(
  parameter bit IS_LSB = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  pbus_ctl_t ctl,
  input  pbus_src_t src,
  output logic      sb,
  output logic      db,
  output logic      adl,
  output logic      adh,
  output logic      pcl,
  output logic      pch
);
  logic gnd_sel;
  logic dl_db_en, dl_adl_en, dl_adh_en;
  logic sb_loc, db_loc, adh_loc;
  logic db2sb, sb2db, adh2sb, sb2adh;

  // The address-high ground line differs between bit 0 and the others.
  generate
    if (IS_LSB) begin : g_gnd_lo
      assign gnd_sel = ctl.z_lo;
    end else begin : g_gnd_hi
      assign gnd_sel = ctl.z_hi;
    end
  endgenerate

  assign dl_db_en  = ctl.ph1 & ctl.dl_db;
  assign dl_adl_en = ctl.ph1 & ctl.dl_adl;
  assign dl_adh_en = ctl.ph1 & ctl.dl_adh;

  // Local drive on each side of a link (not through the link itself).
  assign sb_loc  = ctl.y_sb | ctl.x_sb | ctl.s_sb | ctl.alu_sb | ctl.a_sb;
  assign db_loc  = ctl.a_db | ctl.pch_db | ctl.pcl_db | dl_db_en;
  assign adh_loc = gnd_sel | ctl.pch_adh | dl_adh_en;

  assign db2sb  = db_loc  & ctl.lnk_db;
  assign sb2db  = sb_loc  & ctl.lnk_db;
  assign adh2sb = adh_loc & ctl.lnk_adh;
  assign sb2adh = sb_loc  & ctl.lnk_adh;

  pbus_node #(.N(SB_N)) u_sb (
    .clk(clk), .rst(rst),
    .sel({ctl.ph2, ctl.y_sb, ctl.x_sb, ctl.s_sb, ctl.alu_sb, ctl.a_sb, db2sb, adh2sb}),
    .din({1'b1,    src.y,    src.x,    src.s,    src.alu,    src.a,    db,    adh}),
    .q(sb)
  );

  pbus_node #(.N(DB_N)) u_db (
    .clk(clk), .rst(rst),
    .sel({ctl.ph2, ctl.a_db, ctl.pch_db, ctl.pcl_db, dl_db_en, sb2db}),
    .din({1'b1,    src.a,    src.pch,    src.pcl,    src.dl,   sb}),
    .q(db)
  );

  pbus_node #(.N(ADL_N)) u_adl (
    .clk(clk), .rst(rst),
    .sel({ctl.ph2, ctl.s_adl, ctl.alu_adl, ctl.pcl_adl, dl_adl_en}),
    .din({1'b1,    src.s,     src.alu,     src.pcl,     src.dl}),
    .q(adl)
  );

  pbus_node #(.N(ADH_N)) u_adh (
    .clk(clk), .rst(rst),
    .sel({ctl.ph2, gnd_sel, ctl.pch_adh, dl_adh_en, sb2adh}),
    .din({1'b1,    1'b0,    src.pch,     src.dl,    sb}),
    .q(adh)
  );

  pbus_node #(.N(PC_N)) u_pcl (
    .clk(clk), .rst(rst),
    .sel({ctl.pcl_pcl, ctl.adl_pcl}),
    .din({src.pcl,     adl}),
    .q(pcl)
  );

  pbus_node #(.N(PC_N)) u_pch (
    .clk(clk), .rst(rst),
    .sel({ctl.pch_pch, ctl.adh_pch}),
    .din({src.pch,     adh}),
    .q(pch)
  );
endmodule

// File: rtl/pbus_fabric.sv
module pbus_fabric
  import pbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ph1,
  input  logic         ph2,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] pcl_in,
  input  logic [W-1:0] pch_in,
  input  logic [W-1:0] alu_in,
  input  logic [W-1:0] dl_in,
  input  logic         y_to_sb,
  input  logic         x_to_sb,
  input  logic         s_to_sb,
  input  logic         alu_to_sb,
  input  logic         a_to_sb,
  input  logic         a_to_db,
  input  logic         pch_to_db,
  input  logic         pcl_to_db,
  input  logic         dl_to_db,
  input  logic         s_to_adl,
  input  logic         alu_to_adl,
  input  logic         pcl_to_adl,
  input  logic         dl_to_adl,
  input  logic         pch_to_adh,
  input  logic         dl_to_adh,
  input  logic         zero_adh_lo,
  input  logic         zero_adh_hi,
  input  logic         sb_db_link,
  input  logic         sb_adh_link,
  input  logic         pcl_to_pcl,
  input  logic         adl_to_pcl,
  input  logic         pch_to_pch,
  input  logic         adh_to_pch,
  output logic [W-1:0] sb_q,
  output logic [W-1:0] db_q,
  output logic [W-1:0] adl_q,
  output logic [W-1:0] adh_q,
  output logic [W-1:0] pcl_nx,
  output logic [W-1:0] pch_nx
);
  pbus_ctl_t ctl;

  always_comb begin
    ctl.ph1     = ph1;
    ctl.ph2     = ph2;
    ctl.y_sb    = y_to_sb;
    ctl.x_sb    = x_to_sb;
    ctl.s_sb    = s_to_sb;
    ctl.alu_sb  = alu_to_sb;
    ctl.a_sb    = a_to_sb;
    ctl.a_db    = a_to_db;
    ctl.pch_db  = pch_to_db;
    ctl.pcl_db  = pcl_to_db;
    ctl.dl_db   = dl_to_db;
    ctl.s_adl   = s_to_adl;
    ctl.alu_adl = alu_to_adl;
    ctl.pcl_adl = pcl_to_adl;
    ctl.dl_adl  = dl_to_adl;
    ctl.pch_adh = pch_to_adh;
    ctl.dl_adh  = dl_to_adh;
    ctl.z_lo    = zero_adh_lo;
    ctl.z_hi    = zero_adh_hi;
    ctl.lnk_db  = sb_db_link;
    ctl.lnk_adh = sb_adh_link;
    ctl.pcl_pcl = pcl_to_pcl;
    ctl.adl_pcl = adl_to_pcl;
    ctl.pch_pch = pch_to_pch;
    ctl.adh_pch = adh_to_pch;
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      pbus_src_t src;
      assign src = '{x: x_in[g], y: y_in[g], a: a_in[g], s: s_in[g],
                     pcl: pcl_in[g], pch: pch_in[g], alu: alu_in[g], dl: dl_in[g]};

      pbus_slice #(.IS_LSB(g == 0)) u_slice (
        .clk(clk),
        .rst(rst),
        .ctl(ctl),
        .src(src),
        .sb(sb_q[g]),
        .db(db_q[g]),
        .adl(adl_q[g]),
        .adh(adh_q[g]),
        .pcl(pcl_nx[g]),
        .pch(pch_nx[g])
      );
    end
  endgenerate
endmodule

// File: rtl/pbus_fabric_chk.sv
module pbus_fabric_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ph1,
  input logic         ph2,
  input logic [W-1:0] x_in,
  input logic [W-1:0] y_in,
  input logic [W-1:0] pcl_in,
  input logic [W-1:0] pch_in,
  input logic         y_to_sb,
  input logic         x_to_sb,
  input logic         s_to_sb,
  input logic         alu_to_sb,
  input logic         a_to_sb,
  input logic         a_to_db,
  input logic         pch_to_db,
  input logic         pcl_to_db,
  input logic         dl_to_db,
  input logic         zero_adh_lo,
  input logic         zero_adh_hi,
  input logic         sb_db_link,
  input logic         sb_adh_link,
  input logic         pcl_to_pcl,
  input logic         adl_to_pcl,
  input logic         pch_to_pch,
  input logic         adh_to_pch,
  input logic [W-1:0] sb_q,
  input logic [W-1:0] db_q,
  input logic [W-1:0] adl_q,
  input logic [W-1:0] adh_q,
  input logic [W-1:0] pcl_nx,
  input logic [W-1:0] pch_nx
);
  logic sb_quiet;
  assign sb_quiet = !y_to_sb && !x_to_sb && !s_to_sb && !alu_to_sb && !a_to_sb &&
                    !sb_db_link && !sb_adh_link;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sb_q == '0 && db_q == '0 && adl_q == '0 && adh_q == '0 &&
             pcl_nx == '0 && pch_nx == '0));

  assert_precharge_R2: assert property (@(posedge clk) disable iff (rst)
    (ph2 && sb_quiet) |=> sb_q == '1);

  assert_wired_and_R3: assert property (@(posedge clk) disable iff (rst)
    (x_to_sb && y_to_sb && !ph2 && !s_to_sb && !alu_to_sb && !a_to_sb &&
     !sb_db_link && !sb_adh_link) |=> sb_q == $past(x_in & y_in));

  assert_float_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ph2 && sb_quiet) |=> $stable(sb_q));

  assert_pcl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!pcl_to_pcl && !adl_to_pcl) |=> $stable(pcl_nx));

  assert_latch_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!ph1 && !ph2 && dl_to_db && !a_to_db && !pch_to_db && !pcl_to_db && !sb_db_link)
    |=> $stable(db_q));

  assert_ground_lo_R8: assert property (@(posedge clk) disable iff (rst)
    zero_adh_lo |=> adh_q[0] == 1'b0);

  assert_ground_hi_R8: assert property (@(posedge clk) disable iff (rst)
    zero_adh_hi |=> adh_q[W-1:1] == '0);

  assert_pcl_take_R9: assert property (@(posedge clk) disable iff (rst)
    (pcl_to_pcl && !adl_to_pcl) |=> pcl_nx == $past(pcl_in));

  assert_pch_take_R9: assert property (@(posedge clk) disable iff (rst)
    (pch_to_pch && !adh_to_pch) |=> pch_nx == $past(pch_in));
endmodule

bind pbus_fabric pbus_fabric_chk #(.W(W)) chk_i (.*);

// File: tb/pbus_fabric_tb_top.sv
module pbus_fabric_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic ph1, ph2;
  logic [W-1:0] x_in, y_in, a_in, s_in, pcl_in, pch_in, alu_in, dl_in;
  logic y_to_sb, x_to_sb, s_to_sb, alu_to_sb, a_to_sb;
  logic a_to_db, pch_to_db, pcl_to_db, dl_to_db;
  logic s_to_adl, alu_to_adl, pcl_to_adl, dl_to_adl;
  logic pch_to_adh, dl_to_adh, zero_adh_lo, zero_adh_hi;
  logic sb_db_link, sb_adh_link;
  logic pcl_to_pcl, adl_to_pcl, pch_to_pch, adh_to_pch;
  logic [W-1:0] sb_q, db_q, adl_q, adh_q, pcl_nx, pch_nx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pbus_fabric #(.W(W)) dut_i (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    ph1 = 0; ph2 = 0;
    y_to_sb = 0; x_to_sb = 0; s_to_sb = 0; alu_to_sb = 0; a_to_sb = 0;
    a_to_db = 0; pch_to_db = 0; pcl_to_db = 0; dl_to_db = 0;
    s_to_adl = 0; alu_to_adl = 0; pcl_to_adl = 0; dl_to_adl = 0;
    pch_to_adh = 0; dl_to_adh = 0; zero_adh_lo = 0; zero_adh_hi = 0;
    sb_db_link = 0; sb_adh_link = 0;
    pcl_to_pcl = 0; adl_to_pcl = 0; pch_to_pch = 0; adh_to_pch = 0;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic precharge();
    clr(); ph2 = 1; step(); clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr();
    rst = 1;
    {x_in, y_in, a_in, s_in, pcl_in, pch_in, alu_in, dl_in} = '0;
    @(negedge clk);
    ph2 = 1; pcl_to_pcl = 1; pcl_in = 8'hFF;   // reset must override
    step(); step();
    // R1: every node cleared
    chk("R1 sb", sb_q, 8'h00);   chk("R1 db", db_q, 8'h00);
    chk("R1 adl", adl_q, 8'h00); chk("R1 adh", adh_q, 8'h00);
    chk("R1 pcl", pcl_nx, 8'h00); chk("R1 pch", pch_nx, 8'h00);
    rst = 0;

    // R2: precharge lifts all four buses; PC latch nodes untouched (R4)
    precharge();
    chk("R2 sb", sb_q, 8'hFF);   chk("R2 db", db_q, 8'hFF);
    chk("R2 adl", adl_q, 8'hFF); chk("R2 adh", adh_q, 8'hFF);
    chk("R4 pcl idle", pcl_nx, 8'h00);

    // R3: wired-AND, swept over all values of X
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] xv, yv;
      xv = 8'(v);
      yv = {xv[3:0], xv[7:4]} ^ 8'h96;
      clr(); x_in = xv; y_in = yv; x_to_sb = 1; y_to_sb = 1;
      a_in = ~xv; pcl_in = 8'h5F; a_to_db = 1; pcl_to_db = 1;
      step();
      chk("R3 sb", sb_q, xv & yv);
      chk("R3 db", db_q, ~xv & 8'h5F);
    end

    // R4: undriven buses keep their value
    clr(); x_in = 8'hC6; x_to_sb = 1; step();
    clr(); step(); step(); step();
    chk("R4 sb hold", sb_q, 8'hC6);

    // R5 / R11: special bus to data bus, one edge per hop
    precharge();
    x_in = 8'h5A; x_to_sb = 1; sb_db_link = 1;
    step();
    chk("R11 sb first", sb_q, 8'h5A);
    chk("R11 db lags", db_q, 8'hFF);
    step();
    chk("R5 sb to db", db_q, 8'h5A);
    clr(); a_in = 8'h3C; a_to_db = 1; sb_db_link = 1;
    step(); step();
    chk("R5 db to sb", sb_q, 8'h3C);
    clr(); a_in = 8'hC3; a_to_db = 1;
    step(); step();
    chk("R5 link off db", db_q, 8'hC3);
    chk("R5 link off sb", sb_q, 8'h3C);

    // R6: special bus and address-high bus
    precharge();
    x_in = 8'hA5; x_to_sb = 1; sb_adh_link = 1;
    step(); step();
    chk("R6 sb to adh", adh_q, 8'hA5);
    chk("R6 db untouched", db_q, 8'hFF);
    clr(); pch_in = 8'h69; pch_to_adh = 1; sb_adh_link = 1;
    step(); step();
    chk("R6 adh to sb", sb_q, 8'h69);

    // R7: data latch blocked outside phase 1, passes in phase 1
    precharge();
    dl_in = 8'h42; dl_to_db = 1; dl_to_adl = 1; dl_to_adh = 1;
    step();
    chk("R7 db blocked", db_q, 8'hFF);
    chk("R7 adl blocked", adl_q, 8'hFF);
    chk("R7 adh blocked", adh_q, 8'hFF);
    for (int v = 0; v < 256; v++) begin
      clr(); ph1 = 1; dl_in = 8'(v); dl_to_db = 1; dl_to_adl = 1; dl_to_adh = 1;
      step();
      chk("R7 db", db_q, 8'(v));
      chk("R7 adl", adl_q, 8'(v));
      chk("R7 adh", adh_q, 8'(v));
    end

    // R8: ground lines, alone and against a driver
    precharge(); zero_adh_lo = 1; step();
    chk("R8 bit0", adh_q, 8'hFE);
    precharge(); zero_adh_hi = 1; step();
    chk("R8 bits7..1", adh_q, 8'h01);
    precharge(); pch_in = 8'hFF; pch_to_adh = 1; zero_adh_lo = 1; step();
    chk("R8 ground wins", adh_q, 8'hFE);
    clr(); pch_in = 8'hFF; pch_to_adh = 1; zero_adh_hi = 1; step();
    chk("R8 ground wins hi", adh_q, 8'h01);

    // R9: program-counter latch nodes
    for (int v = 0; v < 256; v++) begin
      clr(); pcl_in = 8'(v); pcl_to_pcl = 1; pch_in = ~8'(v); pch_to_pch = 1;
      step();
      chk("R9 pcl", pcl_nx, 8'(v));
      chk("R9 pch", pch_nx, ~8'(v));
    end
    clr(); s_in = 8'h77; s_to_adl = 1; step();
    clr(); adl_to_pcl = 1; step();
    chk("R9 adl to pcl", pcl_nx, 8'h77);
    clr(); pcl_in = 8'hF0; pcl_to_pcl = 1; adl_to_pcl = 1; step();
    chk("R9 pcl and", pcl_nx, 8'h70);
    clr(); step(); step();
    chk("R4 pcl hold", pcl_nx, 8'h70);
    clr(); pch_in = 8'h3E; pch_to_adh = 1; step();
    clr(); adh_to_pch = 1; step();
    chk("R9 adh to pch", pch_nx, 8'h3E);

    // R10: decrement through precharge and float, every register value
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] expv;
      clr(); x_in = 8'(v); x_to_sb = 1; step();   // leave a non-FF value first
      precharge();
      ph1 = 1; step(); step();
      if (v % 32 == 0) chk("R10 float ff", sb_q, 8'hFF);
      alu_in = 8'(v) + sb_q;                      // bench adder
      clr(); alu_to_sb = 1; step();
      expv = (v == 0) ? 8'hFF : 8'(v - 1);
      chk("R10 decrement", sb_q, expv);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule